// File: doc/BRIEF.md
# BCD Mantissa Digit Shifter and Normalizer

This block moves the digits of a twelve-digit packed-BCD mantissa held in a 48-bit register. It handles four operations. The first is a right shift by a count of digits. The second and third are single-digit right and left shifts. The fourth normalizes the mantissa so that its most significant digit is nonzero. The most significant digit sits in bits 47:44 and the least significant digit in bits 3:0. A 4-bit accumulator digit supplies the digit that is shifted in. The digit that falls off the end is returned to that accumulator and to a 4-bit shift-extension register that the block owns. The block also owns a decimal-carry flag, which it clears or sets as each operation finishes.

A command strobe loads the operation, the mantissa, the accumulator digit and a 4-bit count in one cycle. The block then performs one digit shift per clock. It raises a single-cycle done pulse, together with write strobes for the accumulator or the count register, when the result is ready on its outputs. Strobes that arrive while the block is busy are dropped.

Top module: `bcd_digit_shifter`

## Requirements
- R1: After reset, busy, done, acc_we, cnt_we, dc_flag, ext_digit, acc_out and cnt_out are all zero.
- R2: A command strobe is taken only when busy is low. A strobe raised while busy is high changes neither the running operation's result nor its done timing, and it produces no extra done pulse.
- R3: Operation code 01 (single right shift) yields mant_in shifted right by four bits with zero in bits 47:44. The dropped bits 3:0 go to both acc_out and ext_digit, acc_we pulses, and dc_flag is cleared.
- R4: Operation code 10 (single left shift) yields mant_in shifted left by four bits, truncated to 48 bits, with acc_in in bits 3:0. The old bits 47:44 go to both acc_out and ext_digit, acc_we pulses, and dc_flag is cleared.
- R5: Operation code 00 (counted right shift) performs cnt_in single-digit right steps. The first step inserts acc_in at bits 47:44 and every later step inserts zero. After each step ext_digit holds the digit just dropped. At the end acc_out takes the final ext_digit, acc_we pulses, and dc_flag is cleared.
- R6: Operation code 00 with cnt_in equal to zero leaves the mantissa unchanged, sets both ext_digit and acc_out to acc_in, and clears dc_flag.
- R7: Operation code 11 (normalize) shifts left with zero fill while bits 47:44 are zero. cnt_out receives the number of shifts and cnt_we pulses. When a nonzero digit is reached, dc_flag is cleared. acc_we stays low, and ext_digit is not changed.
- R8: Normalize of an all-zero mantissa stops after 12 shifts. It gives cnt_out equal to 12, sets dc_flag, and outputs a zero mantissa.
- R9: done is high for exactly one cycle per accepted command, and only while busy is low. Counting the accepting clock edge as edge 1, done is first seen after edge L, where L depends on the operation:
  - single right or left shift: L = 2
  - counted right shift of n digits: L = n + 1
  - normalize with k < 12 leading zeros: L = k + 2
  - normalize of an all-zero mantissa: L = 13
- R10: A command strobe raised in the cycle in which done is high is accepted and runs to a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation: 00 counted right, 01 right one, 10 left one, 11 normalize |
| mant_in | input | 48 | Mantissa operand |
| acc_in | input | 4 | Accumulator digit |
| cnt_in | input | 4 | Digit count for the counted right shift |
| mant_out | output | 48 | Mantissa result |
| acc_out | output | 4 | Accumulator digit to write back |
| acc_we | output | 1 | Accumulator write strobe, one cycle |
| cnt_out | output | 4 | Normalize shift count |
| cnt_we | output | 1 | Count register write strobe, one cycle |
| ext_digit | output | 4 | Shift-extension register |
| dc_flag | output | 1 | Decimal-carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
Two events can meet in one cycle: completion of one operation and acceptance of the next. The bench waits until it sees done high. In that same cycle it raises a new strobe with a different operation, then checks that the second result and its latency are exact. A related case places a strobe in the first busy cycle of a five-digit counted shift. The bench judges that case by checking three things: the first result is unchanged, its latency is unchanged, and no second done pulse follows.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
    typedef enum logic [1:0] {
        OP_SHR_CNT = 2'b00,
        OP_SHR_ONE = 2'b01,
        OP_SHL_ONE = 2'b10,
        OP_NORM    = 2'b11
    } bsn_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bsn_state_e;
endpackage

// File: rtl/bsn_digit_shift.sv
module bsn_digit_shift #(
    parameter int DIGITS   = 12,
    parameter int DW       = 4,
    parameter bit SHIFT_LT = 1'b0
) (
    input  logic [DIGITS*DW-1:0] mant_i,
    input  logic [DW-1:0]        fill_i,
    output logic [DIGITS*DW-1:0] mant_o,
    output logic [DW-1:0]        drop_o
);
    localparam int MW = DIGITS * DW;

    generate
        if (SHIFT_LT) begin : g_left
            always_comb begin
                mant_o = {mant_i[MW-DW-1:0], fill_i};
                drop_o = mant_i[MW-1 -: DW];
            end
        end else begin : g_right
            always_comb begin
                mant_o = {fill_i, mant_i[MW-1:DW]};
                drop_o = mant_i[DW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/bsn_nib_zero.sv
module bsn_nib_zero #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] nib_i,
    output logic          zero_o
);
    always_comb zero_o = (nib_i == '0);
endmodule

// File: rtl/bcd_digit_shifter.sv
module bcd_digit_shifter #(
    parameter int DIGITS = 12,
    parameter int DW     = 4,
    parameter int CW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [DIGITS*DW-1:0] mant_in,
    input  logic [DW-1:0]        acc_in,
    input  logic [CW-1:0]        cnt_in,
    output logic [DIGITS*DW-1:0] mant_out,
    output logic [DW-1:0]        acc_out,
    output logic                 acc_we,
    output logic [CW-1:0]        cnt_out,
    output logic                 cnt_we,
    output logic [DW-1:0]        ext_digit,
    output logic                 dc_flag,
    output logic                 busy,
    output logic                 done
);
    import bsn_pkg::*;

    localparam int MW = DIGITS * DW;
    localparam logic [CW-1:0] FULL_CNT = CW'(DIGITS);

    typedef struct packed {
        bsn_state_e    state;
        bsn_op_e       op;
        logic [MW-1:0] mant;
        logic [DW-1:0] acc;
        logic [DW-1:0] ext;
        logic          dc;
        logic [CW-1:0] steps;
        logic [CW-1:0] nz;
        logic          first;
        logic          done;
        logic          acc_we;
        logic [CW-1:0] cnt_out;
        logic          cnt_we;
    } regs_t;

    regs_t q, d;

    logic [MW-1:0] rs_mant, ls_mant;
    logic [DW-1:0] rs_drop, ls_drop, rs_fill, ls_fill;
    logic          top_zero;

    always_comb begin
        rs_fill = (q.op == OP_SHR_CNT && q.first) ? q.acc : '0;
        ls_fill = (q.op == OP_NORM) ? '0 : q.acc;
    end

    bsn_digit_shift #(.DIGITS(DIGITS), .DW(DW), .SHIFT_LT(1'b0)) u_rshift (
        .mant_i(q.mant), .fill_i(rs_fill), .mant_o(rs_mant), .drop_o(rs_drop)
    );

    bsn_digit_shift #(.DIGITS(DIGITS), .DW(DW), .SHIFT_LT(1'b1)) u_lshift (
        .mant_i(q.mant), .fill_i(ls_fill), .mant_o(ls_mant), .drop_o(ls_drop)
    );

    bsn_nib_zero #(.DW(DW)) u_topz (
        .nib_i(q.mant[MW-1 -: DW]), .zero_o(top_zero)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.acc_we = 1'b0;
        d.cnt_we = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.op    = bsn_op_e'(cmd_op);
                    d.mant  = mant_in;
                    d.acc   = acc_in;
                    d.first = 1'b1;
                    d.nz    = '0;
                    d.steps = CW'(1);
                    d.state = ST_RUN;
                    if (bsn_op_e'(cmd_op) == OP_SHR_CNT) begin
                        d.ext   = acc_in;
                        d.steps = cnt_in;
                        if (cnt_in == '0) begin
                            d.state  = ST_IDLE;
                            d.done   = 1'b1;
                            d.acc_we = 1'b1;
                            d.dc     = 1'b0;
                        end
                    end
                end
            end
            default: begin
                case (q.op)
                    OP_SHR_CNT, OP_SHR_ONE: begin
                        d.mant  = rs_mant;
                        d.ext   = rs_drop;
                        d.first = 1'b0;
                        d.steps = q.steps - CW'(1);
                        if (q.steps == CW'(1)) begin
                            d.state  = ST_IDLE;
                            d.done   = 1'b1;
                            d.acc    = rs_drop;
                            d.acc_we = 1'b1;
                            d.dc     = 1'b0;
                        end
                    end
                    OP_SHL_ONE: begin
                        d.mant   = ls_mant;
                        d.ext    = ls_drop;
                        d.acc    = ls_drop;
                        d.state  = ST_IDLE;
                        d.done   = 1'b1;
                        d.acc_we = 1'b1;
                        d.dc     = 1'b0;
                    end
                    default: begin
                        if (!top_zero) begin
                            d.state   = ST_IDLE;
                            d.done    = 1'b1;
                            d.cnt_out = q.nz;
                            d.cnt_we  = 1'b1;
                            d.dc      = 1'b0;
                        end else begin
                            d.mant = ls_mant;
                            d.nz   = q.nz + CW'(1);
                            if (q.nz + CW'(1) == FULL_CNT) begin
                                d.state   = ST_IDLE;
                                d.done    = 1'b1;
                                d.cnt_out = FULL_CNT;
                                d.cnt_we  = 1'b1;
                                d.dc      = 1'b1;
                            end
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mant_out  = q.mant;
    assign acc_out   = q.acc;
    assign acc_we    = q.acc_we;
    assign cnt_out   = q.cnt_out;
    assign cnt_we    = q.cnt_we;
    assign ext_digit = q.ext;
    assign dc_flag   = q.dc;
    assign busy      = (q.state == ST_RUN);
    assign done      = q.done;

    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(q.op));

    assert_cnt_we_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |-> (done && !acc_we));

    assert_dc_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cnt_we) |-> !dc_flag);

    assert_norm_partial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_out != FULL_CNT) |-> (!dc_flag && mant_out[MW-1 -: DW] != '0));

    assert_norm_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_out == FULL_CNT) |-> (dc_flag && mant_out == '0));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/bcd_digit_shifter_test.sv
module bcd_digit_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [47:0] mant_in = '0;
    logic [3:0]  acc_in = '0;
    logic [3:0]  cnt_in = '0;
    logic [47:0] mant_out;
    logic [3:0]  acc_out, cnt_out, ext_digit;
    logic        acc_we, cnt_we, dc_flag, busy, done;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bcd_digit_shifter uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .mant_in(mant_in), .acc_in(acc_in), .cnt_in(cnt_in),
        .mant_out(mant_out), .acc_out(acc_out), .acc_we(acc_we),
        .cnt_out(cnt_out), .cnt_we(cnt_we), .ext_digit(ext_digit),
        .dc_flag(dc_flag), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [51:0] ref_shr_cnt(input logic [47:0] m,
                                                input logic [3:0] a,
                                                input int n);
        logic [3:0] e = a;
        for (int i = 0; i < n; i++) begin
            e = m[3:0];
            m = {(i == 0) ? a : 4'h0, m[47:4]};
        end
        return {e, m};
    endfunction

    task automatic drive(input logic [1:0] op, input logic [47:0] m,
                         input logic [3:0] a, input logic [3:0] c);
        cmd_valid = 1'b1; cmd_op = op; mant_in = m; acc_in = a; cnt_in = c;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [47:0] m,
                          input logic [3:0] a, input logic [3:0] c, output int lat);
        @(negedge clk);
        drive(op, m, a, c);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(lat);
    endtask

    task automatic pulse_end(input string req);
        @(negedge clk);
        chk(!done, req, "done_second_cycle", done, 0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !acc_we && !cnt_we, "R1", "ctrl", {busy, done, acc_we, cnt_we}, 0);
        chk(!dc_flag && ext_digit == 0, "R1", "dc_ext", {dc_flag, ext_digit}, 0);
        chk(acc_out == 0 && cnt_out == 0, "R1", "acc_cnt", {acc_out, cnt_out}, 0);
    endtask

    task automatic t_norm_zero;
        int lat;
        run_op(2'b11, 48'h0, 4'h3, 4'h0, lat);
        chk(lat == 13, "R9", "norm_zero_latency", lat, 13);
        chk(cnt_out == 12 && cnt_we, "R8", "norm_zero_cnt", cnt_out, 12);
        chk(dc_flag == 1'b1 && mant_out == 0, "R8", "norm_zero_dc_mant", {dc_flag, mant_out}, {1'b1, 48'h0});
        chk(!acc_we, "R7", "norm_no_acc_we", acc_we, 0);
        pulse_end("R9");
    endtask

    task automatic t_shr_one;
        int lat;
        run_op(2'b01, 48'h987654321098, 4'h7, 4'h9, lat);
        chk(lat == 2, "R9", "shr1_latency", lat, 2);
        chk(mant_out == 48'h098765432109, "R3", "shr1_mant", mant_out, 48'h098765432109);
        chk(acc_out == 8 && ext_digit == 8 && acc_we, "R3", "shr1_digit", {acc_out, ext_digit}, 8'h88);
        chk(!dc_flag, "R3", "shr1_dc_cleared", dc_flag, 0);
        pulse_end("R9");
    endtask

    task automatic t_shl_one;
        int lat;
        run_op(2'b10, 48'h912345678901, 4'h5, 4'h0, lat);
        chk(lat == 2, "R9", "shl1_latency", lat, 2);
        chk(mant_out == 48'h123456789015, "R4", "shl1_mant", mant_out, 48'h123456789015);
        chk(acc_out == 9 && ext_digit == 9 && acc_we, "R4", "shl1_digit", {acc_out, ext_digit}, 8'h99);
        chk(!dc_flag, "R4", "shl1_dc", dc_flag, 0);
    endtask

    task automatic t_shr_cnt(input logic [47:0] m, input logic [3:0] a, input int n);
        int lat;
        logic [51:0] r;
        r = ref_shr_cnt(m, a, n);
        run_op(2'b00, m, a, 4'(n), lat);
        chk(lat == n + 1, "R9", "shrn_latency", lat, n + 1);
        chk(mant_out == r[47:0], "R5", "shrn_mant", mant_out, r[47:0]);
        chk(ext_digit == r[51:48] && acc_out == r[51:48] && acc_we, "R5", "shrn_digit",
            {acc_out, ext_digit}, {r[51:48], r[51:48]});
        chk(!dc_flag, "R5", "shrn_dc", dc_flag, 0);
    endtask

    task automatic t_shr_zero;
        int lat;
        run_op(2'b11, 48'h0, 4'h0, 4'h0, lat);
        run_op(2'b00, 48'h123456789012, 4'hb, 4'h0, lat);
        chk(lat == 1, "R6", "shr0_latency", lat, 1);
        chk(mant_out == 48'h123456789012, "R6", "shr0_mant", mant_out, 48'h123456789012);
        chk(ext_digit == 4'hb && acc_out == 4'hb, "R6", "shr0_digit", {acc_out, ext_digit}, 8'hbb);
        chk(!dc_flag, "R6", "shr0_dc", dc_flag, 0);
    endtask

    task automatic t_norm_partial;
        int lat;
        logic [3:0] e0;
        e0 = ext_digit;
        run_op(2'b11, 48'h000450000001, 4'h2, 4'h0, lat);
        chk(lat == 5, "R9", "norm_latency", lat, 5);
        chk(mant_out == 48'h450000001000, "R7", "norm_mant", mant_out, 48'h450000001000);
        chk(cnt_out == 3 && cnt_we && !acc_we, "R7", "norm_cnt", cnt_out, 3);
        chk(!dc_flag && ext_digit == e0, "R7", "norm_dc_ext", {dc_flag, ext_digit}, {1'b0, e0});
        run_op(2'b11, 48'h700000000000, 4'h2, 4'h0, lat);
        chk(lat == 2 && cnt_out == 0, "R7", "norm_none", {lat[7:0], cnt_out}, {8'd2, 4'd0});
    endtask

    task automatic t_busy_ignore;
        int lat;
        logic [51:0] r;
        r = ref_shr_cnt(48'h246802468024, 4'h1, 5);
        @(negedge clk);
        drive(2'b00, 48'h246802468024, 4'h1, 4'd5);
        @(negedge clk);
        drive(2'b10, 48'h111111111111, 4'h9, 4'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(lat);
        lat = lat + 1;
        chk(lat == 6, "R2", "busy_latency", lat, 6);
        chk(mant_out == r[47:0] && acc_out == r[51:48], "R2", "busy_result",
            {acc_out, mant_out}, r);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!done && !busy, "R2", "no_extra_done", {done, busy}, 0);
        end
    endtask

    task automatic t_back_to_back;
        int lat;
        run_op(2'b01, 48'h555555555551, 4'h0, 4'h0, lat);
        drive(2'b10, 48'h312345678901, 4'h6, 4'h0);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(lat);
        chk(lat == 2, "R10", "b2b_latency", lat, 2);
        chk(mant_out == 48'h123456789016 && acc_out == 3, "R10", "b2b_result",
            {acc_out, mant_out}, {4'h3, 48'h123456789016});
    endtask

    initial begin
        #(20 * 5000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_norm_zero();
        t_shr_one();
        t_shl_one();
        t_shr_cnt(48'h123456789012, 4'h6, 3);
        t_shr_cnt(48'h987654321987, 4'h4, 1);
        t_shr_cnt(48'h135791357913, 4'h8, 15);
        t_shr_zero();
        t_norm_partial();
        t_busy_ignore();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule